// File: doc/BRIEF.md
# Multicycle 16-bit Datapath

This block is the storage and arithmetic half of a small multicycle processor. It holds a 32-word register file, a six-function ALU, the working registers A, B, C, MDR, IR and PC, and a one-bit zero flag. It contains no instruction decoder. An external sequencer drives a wide control word every cycle: one write enable for each register and one select for each multiplexer. The datapath carries out exactly what that word asks for at the next rising clock edge.

The block talks to a word-addressed memory of 2^16 sixteen-bit words. It drives an address bus and a write-data bus, and it takes a read-data bus. A read/write strobe passes straight through from the control word. Register fields come from IR: the low five bits name the second operand register, and the next five bits name the first.

The zero flag has no enable and samples the ALU result on every edge. A comparison is therefore usable only in the cycle directly after the subtract that produced it. PC loads are gated by a two-bit condition code combined with that flag.

Top module: `mc16_datapath`

## Requirements
- R1: When rst_n is low at a rising edge, PC, IR, A, B, C, MDR, Z and every register-file entry become zero.
- R2: The ALU function code selects the result: 0 add, 1 subtract (first minus second), 2 AND, 3 OR, 4 XOR, 5 set-less-than (1 if the first operand is below the second as signed two's-complement values, else 0), and 6 or 7 give zero. With ctl_c_we high, C takes the result at the edge.
- R3: The first ALU operand is A when ctl_opa_sel=0 and PC when it is 1. The second operand is B for ctl_opb_sel=00, MDR for 01, the constant 1 for 10, and C for 11.
- R4: Register 0 always reads as zero on both read ports, and writes to it are discarded.
- R5: Read port 1 addresses IR[9:5], or register 0 when ctl_use_r0=1. Read port 2 addresses IR[4:0]. A and B load those ports when their enables are high.
- R6: The write register is IR[4:0] when ctl_wr_rt=1 and IR[9:5] when it is 0. Write data is C for ctl_rfd_sel=00 or 11, MDR for 01, and PC for 10. The write happens only when ctl_rf_we=1.
- R7: Z takes (ALU result == 0) at every edge, with no enable. A conditional PC write therefore uses the result from the cycle just before.
- R8: PC is written only when ctl_pc_we=1. ctl_zmode=00 writes always, 01 writes only if Z=1, 10 writes only if Z=0, and 11 never writes.
- R9: The PC load source is C when ctl_pc_sel=0 and A when it is 1.
- R10: mem_addr is PC for ctl_addr_sel=00 or 11, C for 01, and A for 10. mem_wdata is B when ctl_wd_sel=0 and MDR when it is 1. mem_we equals ctl_rw (1 means write).
- R11: IR and MDR load mem_rdata on their enables. Every register holds its value when its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_a_we | input | 1 | Load A from read port 1 |
| ctl_b_we | input | 1 | Load B from read port 2 |
| ctl_c_we | input | 1 | Load C from ALU result |
| ctl_pc_we | input | 1 | PC write request (gated by ctl_zmode) |
| ctl_rf_we | input | 1 | Register file write enable |
| ctl_ir_we | input | 1 | Load IR from mem_rdata |
| ctl_mdr_we | input | 1 | Load MDR from mem_rdata |
| ctl_rw | input | 1 | Memory strobe, 0 read / 1 write |
| ctl_opa_sel | input | 1 | First ALU operand select |
| ctl_opb_sel | input | 2 | Second ALU operand select |
| ctl_rfd_sel | input | 2 | Register write data select |
| ctl_pc_sel | input | 1 | PC source select |
| ctl_addr_sel | input | 2 | Memory address source select |
| ctl_wd_sel | input | 1 | Memory write data source select |
| ctl_zmode | input | 2 | PC write condition code |
| ctl_use_r0 | input | 1 | Force read port 1 to register 0 |
| ctl_wr_rt | input | 1 | Write register from IR[4:0] instead of IR[9:5] |
| ctl_alu_fn | input | 3 | ALU function code |
| mem_rdata | input | 16 | Memory read data |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |

## Verification
A register result (A, B, C, MDR, IR, PC or a register-file entry) is due one rising edge after its enable is presented. The memory outputs are combinational and follow their selects in the same cycle. Z is set by the edge that ends the ALU cycle, and a conditional PC load is seen one edge after that. The bench therefore drives each control word 1 ns after an edge and lets exactly one edge pass. It then reads the registers back by steering them onto mem_addr or mem_wdata 1 ns later, well before the next edge. The zero-flag checks place the subtract in the cycle right before the conditional PC write. They also place an unrelated nonzero ALU cycle in between, to show that the earlier comparison is lost.

// File: rtl/mc16_pkg.sv
`timescale 1ns/1ps
// Shared select encodings for the multicycle datapath.
// Assumes every control select is driven by an external sequencer.
package mc16_pkg;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_XOR = 3'd4,
        FN_SLT = 3'd5
    } alu_fn_e;

    typedef enum logic [1:0] {
        OPB_B   = 2'd0,
        OPB_MDR = 2'd1,
        OPB_ONE = 2'd2,
        OPB_C   = 2'd3
    } opb_sel_e;

    typedef enum logic [1:0] {
        RFD_C   = 2'd0,
        RFD_MDR = 2'd1,
        RFD_PC  = 2'd2
    } rfd_sel_e;

    typedef enum logic [1:0] {
        ADR_PC = 2'd0,
        ADR_C  = 2'd1,
        ADR_A  = 2'd2
    } adr_sel_e;

    typedef enum logic [1:0] {
        ZM_ALWAYS = 2'd0,
        ZM_IF_SET = 2'd1,
        ZM_IF_CLR = 2'd2,
        ZM_NEVER  = 2'd3
    } zmode_e;

endpackage

// File: rtl/mc16_regfile.sv
`timescale 1ns/1ps
// Register file: NREG words of DW bits, two combinational read ports,
// one write port on the rising edge. Entry 0 reads as zero and is never
// written. Assumes synchronous active-low reset clears every entry.
module mc16_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] raddr1,
    output logic [DW-1:0]  rdata1,
    input  logic [RAW-1:0] raddr2,
    output logic [DW-1:0]  rdata2
);

    logic [DW-1:0] rows [NREG];

    // Clear on reset, otherwise store one word unless it targets entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rows[i] <= '0;
        end else if (we && (waddr != '0)) begin
            rows[waddr] <= wdata;
        end
    end

    // Read ports force zero for entry 0.
    assign rdata1 = (raddr1 == '0) ? '0 : rows[raddr1];
    assign rdata2 = (raddr2 == '0) ? '0 : rows[raddr2];

endmodule

// File: rtl/mc16_alu.sv
`timescale 1ns/1ps
// Combinational ALU with six functions and a zero detect.
// Assumes unused function codes should produce zero.
module mc16_alu
    import mc16_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [2:0]    fn,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res,
    output logic          zero
);

    // Select the function result.
    always_comb begin
        case (fn)
            FN_ADD:  res = opa + opb;
            FN_SUB:  res = opa - opb;
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            FN_XOR:  res = opa ^ opb;
            FN_SLT:  res = {{(DW-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: res = '0;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/mc16_pc_ctl.sv
`timescale 1ns/1ps
// Decides whether PC loads this cycle from the write request, the
// two-bit condition code and the registered zero flag.
module mc16_pc_ctl
    import mc16_pkg::*;
(
    input  logic       pc_we,
    input  logic [1:0] zmode,
    input  logic       z,
    output logic       load
);

    // Gate the write request by the condition code.
    always_comb begin
        case (zmode)
            ZM_ALWAYS: load = pc_we;
            ZM_IF_SET: load = pc_we & z;
            ZM_IF_CLR: load = pc_we & ~z;
            default:   load = 1'b0;
        endcase
    end

endmodule

// File: rtl/mc16_datapath.sv
`timescale 1ns/1ps
// Multicycle datapath: register file, ALU, working registers and PC
// steered entirely by an external per-cycle control word. Assumes the
// sequencer never expects opcode decoding here; register fields are
// IR[2*RAW-1:RAW] (first) and IR[RAW-1:0] (second).
module mc16_datapath
    import mc16_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_a_we,
    input  logic          ctl_b_we,
    input  logic          ctl_c_we,
    input  logic          ctl_pc_we,
    input  logic          ctl_rf_we,
    input  logic          ctl_ir_we,
    input  logic          ctl_mdr_we,
    input  logic          ctl_rw,
    input  logic          ctl_opa_sel,
    input  logic [1:0]    ctl_opb_sel,
    input  logic [1:0]    ctl_rfd_sel,
    input  logic          ctl_pc_sel,
    input  logic [1:0]    ctl_addr_sel,
    input  logic          ctl_wd_sel,
    input  logic [1:0]    ctl_zmode,
    input  logic          ctl_use_r0,
    input  logic          ctl_wr_rt,
    input  logic [2:0]    ctl_alu_fn,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we
);

    localparam int RAW = $clog2(NREG);

    logic [DW-1:0]  pc_q, ir_q, a_q, b_q, c_q, mdr_q;
    logic           z_q;
    logic [RAW-1:0] f_rs, f_rt, rd1_addr, wr_addr;
    logic [DW-1:0]  rd1_data, rd2_data, opa, opb, alu_res, rf_wdata, pc_src;
    logic           alu_zero, pc_load;

    assign f_rs     = ir_q[2*RAW-1:RAW];
    assign f_rt     = ir_q[RAW-1:0];
    assign rd1_addr = ctl_use_r0 ? '0 : f_rs;
    assign wr_addr  = ctl_wr_rt ? f_rt : f_rs;

    mc16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctl_rf_we),
        .waddr  (wr_addr),
        .wdata  (rf_wdata),
        .raddr1 (rd1_addr),
        .rdata1 (rd1_data),
        .raddr2 (f_rt),
        .rdata2 (rd2_data)
    );

    // First ALU operand: A or PC.
    assign opa = ctl_opa_sel ? pc_q : a_q;

    // Second ALU operand: B, MDR, constant one or C.
    always_comb begin
        case (ctl_opb_sel)
            OPB_B:   opb = b_q;
            OPB_MDR: opb = mdr_q;
            OPB_ONE: opb = {{(DW-1){1'b0}}, 1'b1};
            default: opb = c_q;
        endcase
    end

    // Register file write data: C, MDR or PC.
    always_comb begin
        case (ctl_rfd_sel)
            RFD_MDR: rf_wdata = mdr_q;
            RFD_PC:  rf_wdata = pc_q;
            default: rf_wdata = c_q;
        endcase
    end

    // Memory address source: PC, C or A.
    always_comb begin
        case (ctl_addr_sel)
            ADR_C:   mem_addr = c_q;
            ADR_A:   mem_addr = a_q;
            default: mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = ctl_wd_sel ? mdr_q : b_q;
    assign mem_we    = ctl_rw;
    assign pc_src    = ctl_pc_sel ? a_q : c_q;

    mc16_alu #(.DW(DW)) u_alu (
        .fn   (ctl_alu_fn),
        .opa  (opa),
        .opb  (opb),
        .res  (alu_res),
        .zero (alu_zero)
    );

    mc16_pc_ctl u_pcc (
        .pc_we (ctl_pc_we),
        .zmode (ctl_zmode),
        .z     (z_q),
        .load  (pc_load)
    );

    // Operand registers A and B from the two read ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (ctl_a_we) a_q <= rd1_data;
            if (ctl_b_we) b_q <= rd2_data;
        end
    end

    // Result register C from the ALU.
    always_ff @(posedge clk) begin
        if (!rst_n)        c_q <= '0;
        else if (ctl_c_we) c_q <= alu_res;
    end

    // Zero flag samples the ALU every cycle, no enable.
    always_ff @(posedge clk) begin
        if (!rst_n) z_q <= 1'b0;
        else        z_q <= alu_zero;
    end

    // Instruction and memory data registers from the read bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            mdr_q <= '0;
        end else begin
            if (ctl_ir_we)  ir_q  <= mem_rdata;
            if (ctl_mdr_we) mdr_q <= mem_rdata;
        end
    end

    // Program counter, loaded under the condition gate.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (pc_load) pc_q <= pc_src;
    end

endmodule

// File: rtl/mc16_datapath_chk.sv
`timescale 1ns/1ps
// Property checker for mc16_datapath, attached by bind below.
// Assumes it observes the internal registers of the bound instance.
module mc16_datapath_chk #(
    parameter int DW  = 16,
    parameter int RAW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pc_we,
    input logic [1:0]     zmode,
    input logic [DW-1:0]  pc_q,
    input logic [DW-1:0]  pc_src,
    input logic           z_q,
    input logic           alu_zero,
    input logic [RAW-1:0] rd1_addr,
    input logic [DW-1:0]  rd1_data,
    input logic           ir_we,
    input logic [DW-1:0]  ir_q,
    input logic           mdr_we,
    input logic [DW-1:0]  mdr_q,
    input logic [DW-1:0]  mem_rdata
);

    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> $stable(pc_q));

    assert_pc_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && zmode == 2'b11) |=> $stable(pc_q));

    assert_pc_uncond_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && zmode == 2'b00) |=> (pc_q == $past(pc_src)));

    assert_z_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (z_q == $past(alu_zero)));

    assert_r0_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_addr == '0) |-> (rd1_data == '0));

    assert_ir_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_we |=> $stable(ir_q));

    assert_mdr_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mdr_we |=> (mdr_q == $past(mem_rdata)));

endmodule

bind mc16_datapath mc16_datapath_chk #(.DW(DW), .RAW(RAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_we     (ctl_pc_we),
    .zmode     (ctl_zmode),
    .pc_q      (pc_q),
    .pc_src    (pc_src),
    .z_q       (z_q),
    .alu_zero  (alu_zero),
    .rd1_addr  (rd1_addr),
    .rd1_data  (rd1_data),
    .ir_we     (ctl_ir_we),
    .ir_q      (ir_q),
    .mdr_we    (ctl_mdr_we),
    .mdr_q     (mdr_q),
    .mem_rdata (mem_rdata)
);

// File: tb/tb_mc16_datapath.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps ALU functions over operand pairs, the
// zero-flag timing, PC gating, muxes and reset.
module tb_mc16_datapath;

    localparam int CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_we, b_we, c_we, pc_we, rf_we, ir_we, mdr_we, rw;
    logic        opa_sel, pc_sel, wd_sel, use_r0, wr_rt;
    logic [1:0]  opb_sel, rfd_sel, addr_sel, zmode;
    logic [2:0]  alu_fn;
    logic [15:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_we;

    int total = 0;
    int bad   = 0;
    logic [15:0] pc_exp;
    logic [15:0] vals [8];

    always #(CYC/2) clk = ~clk;

    mc16_datapath dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_a_we(a_we), .ctl_b_we(b_we), .ctl_c_we(c_we), .ctl_pc_we(pc_we),
        .ctl_rf_we(rf_we), .ctl_ir_we(ir_we), .ctl_mdr_we(mdr_we), .ctl_rw(rw),
        .ctl_opa_sel(opa_sel), .ctl_opb_sel(opb_sel), .ctl_rfd_sel(rfd_sel),
        .ctl_pc_sel(pc_sel), .ctl_addr_sel(addr_sel), .ctl_wd_sel(wd_sel),
        .ctl_zmode(zmode), .ctl_use_r0(use_r0), .ctl_wr_rt(wr_rt),
        .ctl_alu_fn(alu_fn), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    task automatic clear_ctl();
        a_we = 0; b_we = 0; c_we = 0; pc_we = 0; rf_we = 0; ir_we = 0;
        mdr_we = 0; rw = 0; opa_sel = 0; pc_sel = 0; wd_sel = 0;
        use_r0 = 0; wr_rt = 0; opb_sel = 0; rfd_sel = 0; addr_sel = 0;
        zmode = 0; alu_fn = 0;
    endtask

    // One edge with the current controls, then back to idle.
    task automatic tick();
        @(posedge clk); #1;
        clear_ctl();
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic peek_addr(input logic [1:0] s, output logic [15:0] v);
        addr_sel = s; #1; v = mem_addr; addr_sel = 0;
    endtask

    task automatic peek_wd(input logic s, output logic [15:0] v);
        wd_sel = s; #1; v = mem_wdata; wd_sel = 0;
    endtask

    task automatic load_ir(input logic [15:0] w);
        mem_rdata = w; ir_we = 1; tick();
    endtask

    task automatic rf_write(input logic [4:0] r, input logic [15:0] v);
        load_ir({6'd0, 5'd0, r});
        mem_rdata = v; mdr_we = 1; tick();
        wr_rt = 1; rfd_sel = 2'd1; rf_we = 1; tick();
    endtask

    task automatic load_ab(input logic [4:0] ra, input logic [4:0] rb);
        load_ir({6'd0, ra, rb});
        a_we = 1; b_we = 1; tick();
    endtask

    function automatic logic [15:0] ref_alu(input int f, input logic [15:0] x, input logic [15:0] y);
        case (f)
            0: return x + y;
            1: return x - y;
            2: return x & y;
            3: return x | y;
            4: return x ^ y;
            5: return {15'd0, ($signed(x) < $signed(y))};
            default: return 16'd0;
        endcase
    endfunction

    initial begin
        #(CYC * 150000);
        bad++; total++;
        $display("FAIL watchdog R1 act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
        vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'h00FF; vals[7] = 16'hFF00;
        clear_ctl();
        mem_rdata = 16'h0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        pc_exp = 16'h0;

        // R1: reset state
        peek_addr(2'd0, v); chk("R1 pc", v, 16'h0);
        peek_addr(2'd1, v); chk("R1 c", v, 16'h0);
        peek_addr(2'd2, v); chk("R1 a", v, 16'h0);
        peek_wd(1'b0, v);   chk("R1 b", v, 16'h0);
        peek_wd(1'b1, v);   chk("R1 mdr", v, 16'h0);

        // R2 / R7 / R8: ALU sweep and zero-flag PC gating per operand pair
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                rf_write(5'd1, vals[i]);
                rf_write(5'd2, vals[j]);
                load_ab(5'd1, 5'd2);
                for (int f = 0; f < 8; f++) begin
                    alu_fn = 3'(f); c_we = 1; tick();
                    peek_addr(2'd1, v);
                    chk($sformatf("R2 fn%0d %h,%h", f, vals[i], vals[j]), v, ref_alu(f, vals[i], vals[j]));
                end
                alu_fn = 3'd1; tick();
                pc_we = 1; zmode = 2'd1; pc_sel = 1; tick();
                if (vals[i] == vals[j]) pc_exp = vals[i];
                peek_addr(2'd0, v); chk("R7 z-set pc", v, pc_exp);
                alu_fn = 3'd1; tick();
                pc_we = 1; zmode = 2'd2; pc_sel = 1; tick();
                if (vals[i] != vals[j]) pc_exp = vals[i];
                peek_addr(2'd0, v); chk("R8 z-clr pc", v, pc_exp);
            end
        end

        // R4: register 0 ignores writes and reads zero
        rf_write(5'd0, 16'hBEEF);
        load_ab(5'd0, 5'd0);
        peek_addr(2'd2, v); chk("R4 port1", v, 16'h0);
        peek_wd(1'b0, v);   chk("R4 port2", v, 16'h0);

        // R5: forced register-0 read on port 1
        rf_write(5'd3, 16'h5A5A);
        load_ir({6'd0, 5'd3, 5'd0});
        use_r0 = 1; a_we = 1; tick();
        peek_addr(2'd2, v); chk("R5 use_r0", v, 16'h0);
        a_we = 1; tick();
        peek_addr(2'd2, v); chk("R5 rs read", v, 16'h5A5A);

        // R9 / R3: PC sources and ALU operand selects
        rf_write(5'd1, 16'h0100);
        load_ab(5'd1, 5'd1);
        pc_we = 1; zmode = 2'd0; pc_sel = 1; tick();
        pc_exp = 16'h0100;
        peek_addr(2'd0, v); chk("R9 pc<-a", v, pc_exp);
        opa_sel = 1; opb_sel = 2'd2; alu_fn = 3'd0; c_we = 1; tick();
        peek_addr(2'd1, v); chk("R3 pc+1", v, 16'h0101);
        pc_we = 1; pc_sel = 0; tick();
        pc_exp = 16'h0101;
        peek_addr(2'd0, v); chk("R9 pc<-c", v, pc_exp);
        mem_rdata = 16'h0010; mdr_we = 1; tick();
        opb_sel = 2'd1; alu_fn = 3'd0; c_we = 1; tick();
        peek_addr(2'd1, v); chk("R3 a+mdr", v, 16'h0110);
        opb_sel = 2'd3; alu_fn = 3'd1; c_we = 1; tick();
        peek_addr(2'd1, v); chk("R3 a-c", v, 16'hFFF0);
        opa_sel = 1; opb_sel = 2'd0; alu_fn = 3'd0; c_we = 1; tick();
        peek_addr(2'd1, v); chk("R3 pc+b", v, 16'h0201);

        // R6: write data from PC to rt, from C to rs
        load_ir({6'd0, 5'd6, 5'd5});
        rf_we = 1; wr_rt = 1; rfd_sel = 2'd2; tick();
        load_ab(5'd5, 5'd6);
        peek_addr(2'd2, v); chk("R6 rt<-pc", v, 16'h0101);
        peek_wd(1'b0, v);   chk("R6 rs untouched", v, 16'h0000);
        load_ir({6'd0, 5'd6, 5'd7});
        rf_we = 1; wr_rt = 0; rfd_sel = 2'd0; tick();
        load_ab(5'd6, 5'd7);
        peek_addr(2'd2, v); chk("R6 rs<-c", v, 16'h0201);
        peek_wd(1'b0, v);   chk("R6 rt untouched", v, 16'h0000);

        // R10: memory address, write data and strobe
        peek_addr(2'd3, v); chk("R10 addr sel3", v, pc_exp);
        peek_wd(1'b1, v);   chk("R10 wd mdr", v, 16'h0010);
        rw = 1; #1; chk("R10 we high", {15'd0, mem_we}, 16'h1);
        rw = 0; #1; chk("R10 we low", {15'd0, mem_we}, 16'h0);

        // R11: registers hold without enables while inputs move
        mem_rdata = 16'hDEAD; alu_fn = 3'd4; tick();
        peek_wd(1'b1, v);   chk("R11 mdr hold", v, 16'h0010);
        peek_addr(2'd1, v); chk("R11 c hold", v, 16'h0201);
        a_we = 1; tick();
        peek_addr(2'd2, v); chk("R11 ir hold", v, 16'h0201);

        // R7 / R8: flag lifetime and gate codes
        rf_write(5'd1, 16'h4444);
        rf_write(5'd2, 16'h4444);
        load_ab(5'd1, 5'd2);
        alu_fn = 3'd1; tick();
        alu_fn = 3'd0; tick();
        pc_we = 1; zmode = 2'd1; pc_sel = 1; tick();
        peek_addr(2'd0, v); chk("R7 stale compare", v, pc_exp);
        alu_fn = 3'd1; tick();
        pc_we = 1; zmode = 2'd3; pc_sel = 1; tick();
        peek_addr(2'd0, v); chk("R8 code 11", v, pc_exp);
        alu_fn = 3'd1; tick();
        pc_we = 0; zmode = 2'd0; pc_sel = 1; tick();
        peek_addr(2'd0, v); chk("R8 no we", v, pc_exp);
        alu_fn = 3'd1; tick();
        pc_we = 1; zmode = 2'd2; pc_sel = 1; tick();
        peek_addr(2'd0, v); chk("R8 clr with z", v, pc_exp);
        alu_fn = 3'd1; tick();
        pc_we = 1; zmode = 2'd1; pc_sel = 1; tick();
        pc_exp = 16'h4444;
        peek_addr(2'd0, v); chk("R7 fresh compare", v, pc_exp);

        // R1: mid-run reset
        rst_n = 0; tick(); rst_n = 1;
        peek_addr(2'd0, v); chk("R1 pc again", v, 16'h0);
        peek_addr(2'd1, v); chk("R1 c again", v, 16'h0);
        peek_wd(1'b1, v);   chk("R1 mdr again", v, 16'h0);
        load_ab(5'd1, 5'd3);
        peek_addr(2'd2, v); chk("R1 rf1 cleared", v, 16'h0);
        peek_wd(1'b0, v);   chk("R1 rf3 cleared", v, 16'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule